// File: doc/BRIEF.md
# Ramp Profile DAC Sequencer

This block produces the digital code for one auxiliary DAC channel. It has two modes. In static mode the host writes a level, and that level appears on the output. In ramp mode the host starts playback with a manual trigger. The block then steps through a stored profile table with no further host action. It presents one sample per programmed rate interval, either forwards or backwards through the table. When playback ends, the output holds the last sample played.

The profile table has 64 entries of 10 bits each. At reset it is loaded with a raised-cosine rising edge. The host can replace any or all of the entries through a separate table write port.

Two inputs control the output level:
- Powersave freezes playback and holds the present code.
- Clearing the enable input forces the output to zero.

Top module: `ramp_dac_seq`

## Requirements
- R1: While reset is active, and after it is released, `dac_o` is 0 and `busy_o` is 0. The rate reload value resets to 0.
- R2: A write to address 0 with bit 14 clear loads bits [9:0] as a static level. With `en_i` high, `dac_o` shows this level from the clock edge after the write.
- R3: After reset, table entry i lies within 5 codes of round(1023·sin²(π·i/126)). Entry 0 is exactly 0, entry 63 is exactly 1023, and the entries never decrease.
- R4: A write to address 0 with bit 14 and bit 13 set starts playback and raises `busy_o`. Bit 12 selects the direction: 0 plays entries 0 to 63, 1 plays entries 63 to 0. The first sample appears on `dac_o` at the edge of the write.
- R5: A write to address 1 sets the 16-bit rate reload value R. Each sample stays on `dac_o` for R+1 clock cycles, counted while powersave is low.
- R6: While `busy_o` is high, writes to address 0 are ignored. This covers both static levels and new triggers.
- R7: `busy_o` falls at the edge where the last sample (entry 63 going up, entry 0 going down) appears. That edge is 63·(R+1) cycles after the trigger edge, not counting paused cycles. The output then holds that sample.
- R8: While `psave_i` is high, playback pauses and writes to address 0 are ignored. With `en_i` high, `dac_o` holds its level. When `psave_i` falls, playback resumes where it stopped.
- R9: While `en_i` is low, `dac_o` is 0. The internal level is kept, and it reappears when `en_i` returns high.
- R10: A table write stores `tbl_data_i` at `tbl_addr_i` for later playback. It is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; low forces zero output |
| psave_i | input | 1 | Powersave: pause playback, hold output |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control word, 1 = rate reload |
| reg_wdata_i | input | 16 | Register write data |
| tbl_we_i | input | 1 | Profile table write strobe |
| tbl_addr_i | input | 6 | Profile table write index |
| tbl_data_i | input | 10 | Profile table write data |
| dac_o | output | 10 | DAC code |
| busy_o | output | 1 | Playback in progress |

## Verification
The bench builds the block with its default parameters: 64 entries, 10-bit codes and a 16-bit rate. It drives rates from 0 to 3, so a complete playback of all 64 samples, in both directions, fits within a few hundred cycles. At those rates every hold interval is checked sample by sample, including the zero-rate case of one sample per cycle. The same rates also place writes, triggers and powersave pauses in the middle of a playback.

// File: rtl/ramp_dac_pkg.sv
package ramp_dac_pkg;
  // sin^2 rising edge from a rational sine approximation, rounded
  function automatic int unsigned rc_code(int idx, int depth, int maxv);
    longint m;
    longint q;
    longint n;
    longint d;
    m = longint'(depth - 1);
    q = longint'(idx) * (2 * m - longint'(idx));
    n = 4 * q;
    d = 5 * m * m - q;
    return int'((longint'(maxv) * n * n + (d * d) / 2) / (d * d));
  endfunction
endpackage

// File: rtl/ramp_dac_profile_ram.sv
module ramp_dac_profile_ram
  import ramp_dac_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          lock_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int MAXV = (1 << DW) - 1;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= DW'(rc_code(k, DEPTH, MAXV));
    end else if (we_i && !lock_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ramp_dac_tick.sv
module ramp_dac_tick #(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i || tick_o) cnt_q <= rate_i;
    else if (run_i) cnt_q <= cnt_q - 1'b1;
  end

  AST_RATE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !load_i && rate_i != '0) |=> !tick_o); // R5
endmodule

// File: rtl/ramp_dac_player.sv
module ramp_dac_player #(
  parameter int DEPTH = 64,
  parameter int DW    = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          down_i,
  input  logic          tick_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          load_o,
  output logic [DW-1:0] smp_o,
  output logic          busy_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] pos_q;
  logic [AW-1:0] rem_q;
  logic          down_q;
  logic          busy_q;
  logic [AW-1:0] step;

  assign step      = down_q ? pos_q - 1'b1 : pos_q + 1'b1;
  assign rd_addr_o = trig_i ? (down_i ? LAST : '0) : step;
  assign load_o    = trig_i || (busy_q && tick_i);
  assign smp_o     = rd_data_i;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      rem_q  <= '0;
      down_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (trig_i) begin
      pos_q  <= down_i ? LAST : '0;
      rem_q  <= LAST;
      down_q <= down_i;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      pos_q <= step;
      rem_q <= rem_q - 1'b1;
      if (rem_q == AW'(1)) busy_q <= 1'b0;
    end
  end

  AST_END_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (pos_q == (down_q ? '0 : LAST))); // R7
  AST_NO_RETRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !trig_i); // R6
endmodule

// File: rtl/ramp_dac_seq.sv
module ramp_dac_seq #(
  parameter int DEPTH  = 64,
  parameter int DW     = 10,
  parameter int RATE_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          psave_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [15:0]   reg_wdata_i,
  input  logic          tbl_we_i,
  input  logic [AW-1:0] tbl_addr_i,
  input  logic [DW-1:0] tbl_data_i,
  output logic [DW-1:0] dac_o,
  output logic          busy_o
);
  localparam int MODE_BIT  = 14;
  localparam int START_BIT = 13;
  localparam int DIR_BIT   = 12;

  logic [RATE_W-1:0] rate_q;
  logic [DW-1:0]     dac_q;
  logic              busy;
  logic              ctrl_we, trig, static_we;
  logic              tick, ld;
  logic [AW-1:0]     rd_addr;
  logic [DW-1:0]     rd_data, smp;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign ctrl_we   = reg_we_i && !reg_addr_i && !busy && !psave_i;
  assign trig      = ctrl_we && reg_wdata_i[MODE_BIT] && reg_wdata_i[START_BIT];
  assign static_we = ctrl_we && !reg_wdata_i[MODE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rate_q <= '0;
    else if (reg_we_i && reg_addr_i) rate_q <= reg_wdata_i[RATE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_q <= '0;
    else if (static_we) dac_q <= reg_wdata_i[DW-1:0];
    else if (ld) dac_q <= smp;
  end

  ramp_dac_profile_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .lock_i  (busy),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  ramp_dac_tick #(.RATE_W(RATE_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (trig),
    .run_i  (busy && !psave_i),
    .rate_i (rate_q),
    .tick_o (tick)
  );

  ramp_dac_player #(.DEPTH(DEPTH), .DW(DW)) u_player (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .down_i    (reg_wdata_i[DIR_BIT]),
    .tick_i    (tick),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .load_o    (ld),
    .smp_o     (smp),
    .busy_o    (busy)
  );

  assign dac_o  = en_i ? dac_q : '0;
  assign busy_o = busy;

  AST_PSAVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psave_i && $past(psave_i) && en_i && $past(en_i)) |-> $stable(dac_o)); // R8
  AST_TRIG_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(reg_we_i && !reg_addr_i && reg_wdata_i[MODE_BIT]
                            && reg_wdata_i[START_BIT])); // R4
endmodule

// File: tb/ramp_dac_seq_bench.sv
`timescale 1ns/1ps
module ramp_dac_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        psave_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [5:0]  tbl_addr_i = '0;
  logic [9:0]  tbl_data_i = '0;
  logic [9:0]  dac_o;
  logic        busy_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] mdl [64];

  always #2.5 clk = ~clk;

  ramp_dac_seq u_ramp_dac_seq (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .psave_i(psave_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_data_i(tbl_data_i),
    .dac_o(dac_o), .busy_o(busy_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ideal_rc(int i);
    real s;
    s = $sin(3.14159265358979 * i / 126.0);
    return $rtoi(1023.0 * s * s + 0.5);
  endfunction

  function automatic logic [15:0] trig_word(bit down);
    return 16'h6000 | (down ? 16'h1000 : 16'h0000);
  endfunction

  task automatic wr_reg(bit addr, logic [15:0] v);
    reg_we_i = 1'b1; reg_addr_i = addr; reg_wdata_i = v;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic wr_tbl(int a, logic [9:0] v);
    tbl_we_i = 1'b1; tbl_addr_i = 6'(a); tbl_data_i = v;
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  // full playback checked against mdl; disturb injects ignored writes mid-run
  task automatic run_ramp(bit down, int rate, bit disturb);
    wr_reg(1'b1, 16'(rate));
    wr_reg(1'b0, trig_word(down));
    for (int k = 0; k < 64; k++) begin
      for (int h = 0; h <= rate; h++) begin
        chk("R4/R5 sample", dac_o, mdl[down ? 63 - k : k]);
        chk("R7 busy", busy_o, (k != 63));
        tbl_we_i = disturb && k == 1 && h == 0;
        tbl_addr_i = 6'(down ? 20 : 40);
        tbl_data_i = ~mdl[down ? 20 : 40];
        reg_we_i = disturb && k == 2 && h == 0;
        reg_addr_i = 1'b0;
        reg_wdata_i = (k % 2 == 0) ? trig_word(!down) : 16'h0155;
        @(negedge clk);
        tbl_we_i = 1'b0;
        reg_we_i = 1'b0;
      end
    end
    for (int h = 0; h < 3; h++) begin
      chk("R7 hold final", dac_o, mdl[down ? 0 : 63]);
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int prev;
    int lvl;
    int cnt;
    logic [9:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset dac", dac_o, 0);
    chk("R1 reset busy", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset dac", dac_o, 0);
    chk("R1 after reset busy", busy_o, 0);

    // R3: default profile via up playback at rate 0
    wr_reg(1'b0, trig_word(1'b0));
    prev = 0;
    for (int k = 0; k < 64; k++) begin
      int d;
      d = int'(dac_o) - ideal_rc(k);
      n_chk++;
      if (d > 5 || d < -5) begin
        n_fail++;
        $display("FAIL R3 entry %0d actual=%0d expected=%0d", k, dac_o, ideal_rc(k));
      end
      n_chk++;
      if (int'(dac_o) < prev) begin
        n_fail++;
        $display("FAIL R3 monotonic actual=%0d expected>=%0d", dac_o, prev);
      end
      prev = int'(dac_o);
      mdl[k] = dac_o;
      if (k == 0) chk("R3 first entry", dac_o, 0);
      if (k == 63) chk("R3 last entry", dac_o, 1023);
      chk("R7 busy default", busy_o, (k != 63));
      @(negedge clk);
    end
    run_ramp(1'b1, 0, 1'b0);

    // R2 / R9: static levels
    for (int i = 0; i < 6; i++) begin
      lvl = int'($urandom_range(1023, 0));
      if (i == 0) lvl = 1023;
      wr_reg(1'b0, 16'(lvl));
      chk("R2 static level", dac_o, lvl);
    end
    en_i = 1'b0;
    @(negedge clk);
    chk("R9 disabled zero", dac_o, 0);
    en_i = 1'b1;
    @(negedge clk);
    chk("R9 level restored", dac_o, lvl);

    // R8: static write in powersave ignored, then disabled gives zero
    psave_i = 1'b1;
    wr_reg(1'b0, 16'h0011);
    chk("R8 write ignored in powersave", dac_o, lvl);
    en_i = 1'b0;
    @(negedge clk);
    chk("R9 disabled in powersave", dac_o, 0);
    en_i = 1'b1;
    psave_i = 1'b0;
    @(negedge clk);
    chk("R8 level kept", dac_o, lvl);

    // R10: user table, random rates and directions
    for (int a = 0; a < 64; a++) begin
      mdl[a] = 10'($urandom_range(1023, 0));
      wr_tbl(a, mdl[a]);
    end
    run_ramp(1'b0, 0, 1'b0);
    run_ramp(1'b1, 3, 1'b0);
    for (int i = 0; i < 3; i++) run_ramp(1'($urandom_range(1, 0)), int'($urandom_range(3, 0)), 1'b0);
    // R6 / R10: ignored writes while busy
    run_ramp(1'b0, 2, 1'b1);
    run_ramp(1'b1, 1, 1'b1);

    // R8: pause mid-playback
    wr_reg(1'b1, 16'd2);
    wr_reg(1'b0, trig_word(1'b0));
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      if (busy_o) cnt++;
      @(negedge clk);
    end
    held = dac_o;
    psave_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (busy_o) cnt++;
      @(negedge clk);
      chk("R8 hold in powersave", dac_o, held);
    end
    psave_i = 1'b0;
    while (busy_o && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    chk("R8 busy cycles with pause", cnt, 63 * 3 + 10);
    chk("R7 final after pause", dac_o, mdl[63]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule